// File: doc/BRIEF.md
# Trigger Strobe Sequencer

This block sits between a multichannel photodetector readout chip and its digitiser. When a trigger arrives, it produces the three timing strobes the readout needs. HOLD freezes the shaped analog samples. STOP closes the digitiser's time window. ACCEPT confirms the event. The trigger source is selectable: either the chip's own discriminator output or an asynchronous sync input from outside the board. After a rising trigger edge, the block waits a programmable number of fast-clock cycles and then runs the fixed HOLD, STOP, ACCEPT pattern.

A mode setting decides, strobe by strobe, whether each output is made inside the block or copied from an external pin. This lets a setup that still builds strobes with external pulse logic use the same firmware.

A separate pattern setting routes a test pulse to one or both of two charge-injection outputs. Each injection output has its own enable. An enable that is low means the pad is left in high impedance.

All settings are loaded through one write strobe. They change only while the sequencer is idle.

Top module: `trig_strobe_seq`

## Requirements
- R1: With mode code 0 or 1, the internal sequencer never starts. hold_o, stop_o and accept_o equal ext_hold, ext_stop and ext_accept as sampled at the previous clock edge.
- R2: With mode code 2, hold_o follows ext_hold with one cycle of latency. stop_o and accept_o come from the internal sequence.
- R3: With mode code 3, all three strobes come from the internal sequence.
- R4: On the internal trigger path, hold_o rises D+2 cycles after the first clock edge that sees the trigger high after being low. D is the delay field, and D=0 is legal. One delay step is one fast-clock period, for example 4 ns at 250 MHz.
- R5: Let t=0 be the cycle in which hold_o rises. hold_o stays high for HOLD_W cycles. stop_o is high for PULSE_W cycles starting at t=STOP_OFS. accept_o is high for PULSE_W cycles starting at t=ACC_OFS.
- R6: Source code 3 selects sync_in. Every other code selects disc_trig. Activity on the input that is not selected never starts a sequence.
- R7: sync_in passes through a two-flop synchroniser. Its path therefore adds two cycles, so hold_o rises D+4 cycles after the edge that first samples the rise.
- R8: A rising trigger edge that arrives while a sequence is running is ignored. The sequencer accepts a new edge once the sequence has ended.
- R9: Only rising edges start a sequence. A trigger held high produces exactly one sequence.
- R10: The injection pattern selects the outputs one cycle after test_pulse. Pattern 1 drives output B only. Pattern 2 drives both A and B. Pattern 0 and pattern 3 drive A only. An output whose enable is low carries data 0.
- R11: A configuration write that arrives while a sequence is running is discarded, and the earlier settings stay in force.
- R12: While reset is high, all outputs are 0. After reset the settings are mode 3, source 2, delay DEF_DLY (10) and injection pattern 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads all configuration fields (honoured only when idle) |
| cfg_mode | input | 2 | Strobe mode code |
| cfg_src | input | 2 | Trigger source code |
| cfg_delay | input | DLY_W | Trigger-to-HOLD delay in clock cycles |
| cfg_cal | input | 2 | Injection pattern code |
| disc_trig | input | 1 | Discriminator trigger from the readout chip |
| sync_in | input | 1 | Asynchronous external trigger |
| ext_hold | input | 1 | External HOLD strobe |
| ext_stop | input | 1 | External STOP strobe |
| ext_accept | input | 1 | External ACCEPT strobe |
| test_pulse | input | 1 | Calibration test pulse |
| hold_o | output | 1 | HOLD strobe |
| stop_o | output | 1 | STOP strobe |
| accept_o | output | 1 | ACCEPT strobe |
| inj_a_dat | output | 1 | Injection output A data |
| inj_a_oe | output | 1 | Injection output A enable (low = high impedance) |
| inj_b_dat | output | 1 | Injection output B data |
| inj_b_oe | output | 1 | Injection output B enable (low = high impedance) |

## Verification
Some properties are checked on every cycle:
- an edge pulse lasts one cycle;
- a trigger seen during a running sequence never restarts the delay;
- STOP rises only inside HOLD, and ACCEPT only after STOP has ended;
- in the pass-through modes the sequencer stays idle;
- the settings are frozen while a sequence runs;
- at least one injection output is always enabled, and a disabled output carries 0.

Other behaviour only the bench scenarios can show: the absolute HOLD latency for both trigger paths and for delays including zero, the per-strobe choice between internal and external sources in each mode, rearming after a sequence, and the settings that survive a write made while busy.

// File: rtl/trig_seq_pkg.sv
`timescale 1ns/1ps
package trig_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

  localparam logic [1:0] MODE_HOLD_EXT = 2'd2;
  localparam logic [1:0] MODE_ALL_INT  = 2'd3;
  localparam logic [1:0] SRC_SYNC      = 2'd3;
  localparam logic [1:0] SRC_DISC      = 2'd2;
  localparam logic [1:0] INJ_B_ONLY    = 2'd1;
  localparam logic [1:0] INJ_BOTH      = 2'd2;
endpackage

// File: rtl/trig_edge_det.sv
`timescale 1ns/1ps
module trig_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic lvl;
  logic lvl_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign lvl = din;
    end else begin : g_sync
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh <= '0;
        end else begin
          sh[0] <= din;
          for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign lvl = sh[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R9: an edge indication never lasts two cycles
  p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/strobe_seq.sv
`timescale 1ns/1ps
module strobe_seq
  import trig_seq_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int HOLD_W   = 8,
  parameter int STOP_OFS = 4,
  parameter int ACC_OFS  = 8,
  parameter int PULSE_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             trig,
  input  logic [DLY_W-1:0] delay,
  output logic             idle,
  output logic             hold_int,
  output logic             stop_int,
  output logic             acc_int
);
  localparam int SEQ_LEN = ACC_OFS + PULSE_W;
  localparam int TW      = $clog2(SEQ_LEN + 1);

  seq_state_t       st;
  logic [DLY_W-1:0] dcnt;
  logic [TW-1:0]    tcnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      dcnt <= '0;
      tcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (enable && trig) begin
            st   <= ST_WAIT;
            dcnt <= delay;
          end
        end
        ST_WAIT: begin
          if (dcnt == '0) begin
            st   <= ST_RUN;
            tcnt <= '0;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
        ST_RUN: begin
          if (tcnt == TW'(SEQ_LEN - 1)) st <= ST_IDLE;
          else                          tcnt <= tcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign run      = (st == ST_RUN);
  assign idle     = (st == ST_IDLE);
  assign hold_int = run && (tcnt < TW'(HOLD_W));
  assign stop_int = run && (tcnt >= TW'(STOP_OFS)) && (tcnt < TW'(STOP_OFS + PULSE_W));
  assign acc_int  = run && (tcnt >= TW'(ACC_OFS))  && (tcnt < TW'(ACC_OFS + PULSE_W));

  // R8: a trigger during the strobe pattern never restarts the delay
  p_retrig_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (run && trig) |=> (st != ST_WAIT));
  // R5: STOP starts inside HOLD
  p_stop_in_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_int) |-> hold_int);
  // R5: ACCEPT starts only after STOP has ended
  p_acc_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_int) |-> !stop_int);
  // R1: with internal generation disabled the sequencer stays idle
  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!enable && idle) |=> idle);
  // R4: the remaining delay never exceeds the programmed delay
  p_wait_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> (dcnt <= delay));
endmodule

// File: rtl/inj_route.sv
`timescale 1ns/1ps
module inj_route
  import trig_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pattern,
  input  logic       pulse,
  output logic       a_dat,
  output logic       a_oe,
  output logic       b_dat,
  output logic       b_oe
);
  logic en_a;
  logic en_b;

  always_comb begin
    case (pattern)
      INJ_B_ONLY: {en_a, en_b} = 2'b01;
      INJ_BOTH:   {en_a, en_b} = 2'b11;
      default:    {en_a, en_b} = 2'b10;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_dat <= 1'b0;
      a_oe  <= 1'b0;
      b_dat <= 1'b0;
      b_oe  <= 1'b0;
    end else begin
      a_oe  <= en_a;
      b_oe  <= en_b;
      a_dat <= en_a & pulse;
      b_dat <= en_b & pulse;
    end
  end

  // R10: after the first post-reset edge some injection output is driven
  p_inj_driven_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_oe || b_oe));
  // R10: a released output carries no data
  p_inj_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!a_oe |-> !a_dat) and (!b_oe |-> !b_dat));
endmodule

// File: rtl/trig_strobe_seq.sv
`timescale 1ns/1ps
module trig_strobe_seq
  import trig_seq_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int DEF_DLY     = 10,
  parameter int HOLD_W      = 8,
  parameter int STOP_OFS    = 4,
  parameter int ACC_OFS     = 8,
  parameter int PULSE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_src,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [1:0]       cfg_cal,
  input  logic             disc_trig,
  input  logic             sync_in,
  input  logic             ext_hold,
  input  logic             ext_stop,
  input  logic             ext_accept,
  input  logic             test_pulse,
  output logic             hold_o,
  output logic             stop_o,
  output logic             accept_o,
  output logic             inj_a_dat,
  output logic             inj_a_oe,
  output logic             inj_b_dat,
  output logic             inj_b_oe
);
  logic [1:0]       mode_q;
  logic [1:0]       src_q;
  logic [DLY_W-1:0] dly_q;
  logic [1:0]       cal_q;
  logic             disc_rise;
  logic             sync_rise;
  logic             trig_sel;
  logic             seq_idle;
  logic             hold_int;
  logic             stop_int;
  logic             acc_int;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_ALL_INT;
      src_q  <= SRC_DISC;
      dly_q  <= DLY_W'(DEF_DLY);
      cal_q  <= 2'd0;
    end else if (cfg_we && seq_idle) begin
      mode_q <= cfg_mode;
      src_q  <= cfg_src;
      dly_q  <= cfg_delay;
      cal_q  <= cfg_cal;
    end
  end

  trig_edge_det #(.STAGES(0)) u_disc (
    .clk(clk), .rst(rst), .din(disc_trig), .rise(disc_rise)
  );

  trig_edge_det #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sync_in), .rise(sync_rise)
  );

  assign trig_sel = (src_q == SRC_SYNC) ? sync_rise : disc_rise;

  strobe_seq #(
    .DLY_W(DLY_W), .HOLD_W(HOLD_W), .STOP_OFS(STOP_OFS),
    .ACC_OFS(ACC_OFS), .PULSE_W(PULSE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .enable(mode_q[1]), .trig(trig_sel),
    .delay(dly_q), .idle(seq_idle),
    .hold_int(hold_int), .stop_int(stop_int), .acc_int(acc_int)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o   <= 1'b0;
      stop_o   <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      hold_o   <= (mode_q == MODE_ALL_INT) ? hold_int : ext_hold;
      stop_o   <= mode_q[1] ? stop_int : ext_stop;
      accept_o <= mode_q[1] ? acc_int  : ext_accept;
    end
  end

  inj_route u_inj (
    .clk(clk), .rst(rst), .pattern(cal_q), .pulse(test_pulse),
    .a_dat(inj_a_dat), .a_oe(inj_a_oe), .b_dat(inj_b_dat), .b_oe(inj_b_oe)
  );

  // R11: settings are frozen while a sequence runs
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    !seq_idle |=> ($stable(mode_q) && $stable(src_q) && $stable(dly_q) && $stable(cal_q)));
endmodule

// File: tb/sim_trig_strobe_seq.sv
`timescale 1ns/1ps
module sim_trig_strobe_seq;
  localparam int DLY_W    = 8;
  localparam int HOLD_W   = 8;
  localparam int STOP_OFS = 4;
  localparam int ACC_OFS  = 8;
  localparam int PULSE_W  = 2;
  localparam int SEQ_LEN  = ACC_OFS + PULSE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_src = 2'd0, cfg_cal = 2'd0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic disc_trig = 1'b0, sync_in = 1'b0;
  logic ext_hold = 1'b0, ext_stop = 1'b0, ext_accept = 1'b0, test_pulse = 1'b0;
  logic hold_o, stop_o, accept_o, inj_a_dat, inj_a_oe, inj_b_dat, inj_b_oe;

  int checks = 0, fails = 0, cyc = 0;
  string force_tag = "";
  int cur_mode = 3, cur_src = 2, cur_dly = 10, cur_cal = 0;

  always #2.5 clk = ~clk;

  trig_strobe_seq #(
    .DLY_W(DLY_W), .DEF_DLY(10), .HOLD_W(HOLD_W), .STOP_OFS(STOP_OFS),
    .ACC_OFS(ACC_OFS), .PULSE_W(PULSE_W), .SYNC_STAGES(2)
  ) u0 (.*);

  task automatic chk(input string req, input string sig, input logic act, input logic exp);
    string t;
    t = (force_tag != "") ? force_tag : req;
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", t, sig, cyc, act, exp);
    end
  endtask

  // Strobe pattern from R5; t counts cycles from the expected HOLD rise
  function automatic logic [2:0] model(input int t);
    model = {(t >= 0 && t < HOLD_W),
             (t >= STOP_OFS && t < STOP_OFS + PULSE_W),
             (t >= ACC_OFS && t < ACC_OFS + PULSE_W)};
  endfunction

  // Injection enables {A,B} from R10
  function automatic logic [1:0] inj_oe(input int p);
    case (p)
      1:       inj_oe = 2'b01;
      2:       inj_oe = 2'b11;
      default: inj_oe = 2'b10;
    endcase
  endfunction

  // pat 0: pulse plus a retrigger during the sequence; 1: held level; 2: only unselected input
  task automatic trial(input bit do_cfg, input int m, input int s, input int d, input int c,
                       input int pat, input bit busy_wr);
    int base;
    logic trg, eh, es, ea, tp;
    logic [2:0] mv;
    logic [1:0] oe;
    string hs, ts;
    @(negedge clk);
    disc_trig = 1'b0;
    sync_in   = 1'b0;
    if (do_cfg) begin
      cfg_we = 1'b1; cfg_mode = 2'(m); cfg_src = 2'(s); cfg_delay = DLY_W'(d); cfg_cal = 2'(c);
      @(negedge clk);
      cfg_we = 1'b0;
      cur_mode = m; cur_src = s; cur_dly = d; cur_cal = c;
    end
    @(negedge clk);
    base = cur_dly + 2 + ((cur_src == 3) ? 2 : 0);
    for (int k = 0; k < cur_dly + SEQ_LEN + 12; k++) begin
      trg = (pat == 1) ? 1'b1 : ((k < 3) || (k == base + 3) || (k == base + 4));
      if (pat == 2) begin
        disc_trig = (cur_src == 3) ? trg : 1'b0;
        sync_in   = (cur_src == 3) ? 1'b0 : trg;
      end else begin
        disc_trig = (cur_src == 3) ? 1'($urandom % 2) : trg;
        sync_in   = (cur_src == 3) ? trg : 1'($urandom % 2);
      end
      eh = 1'($urandom % 2); es = 1'($urandom % 2); ea = 1'($urandom % 2); tp = 1'($urandom % 2);
      ext_hold = eh; ext_stop = es; ext_accept = ea; test_pulse = tp;
      cfg_we = busy_wr && (k == base + 1);
      if (cfg_we) begin
        cfg_mode = 2'd1; cfg_src = 2'(cur_src ^ 1); cfg_delay = DLY_W'(3); cfg_cal = 2'(cur_cal ^ 3);
      end
      @(negedge clk);
      cyc = k;
      mv = (pat == 2) ? 3'b000 : model(k - base);
      hs = (pat == 2) ? "R6" : (k == base) ? "R4" : (k > base + ACC_OFS) ? ((pat == 1) ? "R9" : "R8")
         : (cur_src == 3) ? "R7" : "R3";
      if (cur_mode < 2) begin
        chk("R1", "hold_o", hold_o, eh);
        chk("R1", "stop_o", stop_o, es);
        chk("R1", "accept_o", accept_o, ea);
      end else begin
        if (cur_mode == 2) chk("R2", "hold_o", hold_o, eh);
        else               chk(hs, "hold_o", hold_o, mv[2]);
        ts = (cur_mode == 2) ? "R2" : ((pat == 2) ? "R6" : "R5");
        chk(ts, "stop_o", stop_o, mv[1]);
        chk(ts, "accept_o", accept_o, mv[0]);
      end
      oe = inj_oe(cur_cal);
      chk("R10", "inj_a_oe", inj_a_oe, oe[1]);
      chk("R10", "inj_b_oe", inj_b_oe, oe[0]);
      chk("R10", "inj_a_dat", inj_a_dat, oe[1] & tp);
      chk("R10", "inj_b_dat", inj_b_dat, oe[0] & tp);
    end
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C0A));
    // R12: outputs are low during reset
    repeat (3) begin
      @(negedge clk);
      chk("R12", "hold_o", hold_o, 1'b0);
      chk("R12", "stop_o", stop_o, 1'b0);
      chk("R12", "accept_o", accept_o, 1'b0);
      chk("R12", "inj_a_oe", inj_a_oe, 1'b0);
      chk("R12", "inj_b_oe", inj_b_oe, 1'b0);
      chk("R12", "inj_a_dat", inj_a_dat, 1'b0);
      chk("R12", "inj_b_dat", inj_b_dat, 1'b0);
    end
    rst = 1'b0;
    // R12: settings after reset (mode 3, source 2, delay 10, pattern 0)
    force_tag = "R12";
    trial(1'b0, 0, 0, 0, 0, 0, 1'b0);
    force_tag = "";
    // R4 / R7: zero and long delays on both paths
    trial(1'b1, 3, 2, 0, 0, 0, 1'b0);
    trial(1'b1, 3, 3, 0, 1, 0, 1'b0);
    trial(1'b1, 3, 3, 15, 2, 0, 1'b0);
    trial(1'b1, 3, 0, 12, 3, 0, 1'b0);
    // R1 / R2: pass-through modes
    trial(1'b1, 1, 2, 4, 0, 0, 1'b0);
    trial(1'b1, 0, 3, 4, 1, 0, 1'b0);
    trial(1'b1, 2, 2, 6, 2, 0, 1'b0);
    trial(1'b1, 2, 3, 1, 0, 0, 1'b0);
    // R6: only the unselected input toggles
    trial(1'b1, 3, 2, 3, 0, 2, 1'b0);
    trial(1'b1, 3, 3, 3, 2, 2, 1'b0);
    // R9: level-held trigger fires once
    trial(1'b1, 3, 2, 2, 0, 1, 1'b0);
    trial(1'b1, 3, 3, 0, 1, 1, 1'b0);
    // R11: write while busy is dropped; next run uses the earlier settings
    trial(1'b1, 3, 2, 5, 2, 0, 1'b1);
    force_tag = "R11";
    trial(1'b0, 0, 0, 0, 0, 0, 1'b0);
    force_tag = "";
    trial(1'b1, 2, 3, 7, 1, 0, 1'b1);
    force_tag = "R11";
    trial(1'b0, 0, 0, 0, 0, 0, 1'b0);
    force_tag = "";
    // Random settings
    for (int n = 0; n < 24; n++) begin
      trial(1'b1, int'($urandom % 4), int'($urandom % 4), int'($urandom % 21), int'($urandom % 4), 0, 1'b0);
    end
    summary();
    $finish;
  end
endmodule